// File: doc/BRIEF.md
# Vector Indexed Register Gather

This unit carries out one vectorised indexed move over a small register file that it holds. A single pulse on `op_start` captures three base register numbers and an element count. For each element position in turn, the unit reads an index value from the index area, rejects it if it is not below the element count, and copies the register that the index selects inside the source area into the matching slot of the destination area. The index is added to the source base and not to the destination base. As a result, one operation can apply any permutation, and it can copy one source register into several destinations.

Each element's write leaves the unit as a valid/ready stream beat (`wr_valid`, `wr_ready`, `wr_addr`, `wr_data`). While `wr_valid` is high and `wr_ready` is low, the beat holds with unchanged address and data, and the element sequence stalls. A beat is accepted at the rising edge where both are high. Every index and source read comes from the register contents as they were before the operation. The accepted writes are first kept in a staging buffer. They go into the register file together at the end of the operation, also when it ends on a trap. `done` pulses once per operation, and `trap` with `trap_elem` reports an out-of-range index. Outside an operation, a load port fills the registers and a combinational peek port reads them.

Top module: `vgather_unit`

## Requirements
- R1: After reset, every register reads 0 through the peek port, and `busy`, `wr_valid`, `done` and `trap` are low.
- R2: Elements are handled in increasing order i = 0 .. L-1, where L is the effective length. Element i reads its index from register (idx_base+i) mod NREGS. Its beat carries `wr_addr` = (dst_base+i) mod NREGS and `wr_data` = the register at (src_base+index) mod NREGS.
- R3: Index values may repeat and may come in any order. Each element is resolved on its own, so the list 3,7,2,5,1,0,4,6 gives a full permutation and 5,5,3,3,4,4,4 gives duplicates.
- R4: An index, taken as an unsigned DW-bit value, that is greater than or equal to L stops the operation at that element. That element gets no beat. `trap` is high together with `done`, and `trap_elem` gives the element number. Writes accepted earlier are kept, and later elements are not touched.
- R5: All index and source reads see the register contents from before the operation. The accepted writes appear on the peek port from the cycle after `done` and not earlier, so overlapping areas behave as a pure gather.
- R6: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. With `wr_ready` held high, one element completes per clock.
- R7: `done` is a one-cycle pulse. It comes in the cycle after the last accepted beat, or in the cycle after the faulting element is presented. With L = 0 it comes in the cycle after the start, with no beats. With ready held high, `done` is seen L cycles after the start edge, or t+1 cycles after it for a trap at element t.
- R8: The effective length L is `op_len` clamped to VLMAX.
- R9: `op_start` and the load port have no effect while `busy` is high.
- R10: While idle, a load-port write changes the addressed register at the next clock edge, and the peek port shows register contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Start pulse, taken while idle |
| idx_base | input | AW | First register of the index area |
| src_base | input | AW | First register of the source area |
| dst_base | input | AW | First register of the destination area |
| op_len | input | LENW | Requested element count |
| busy | output | 1 | Operation in progress, including the done cycle |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Destination register of the beat |
| wr_data | output | DW | Data of the beat |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Out-of-range index, valid with done |
| trap_elem | output | CW | Faulting element number |
| ld_we | input | 1 | Load-port write enable, idle only |
| ld_addr | input | AW | Load-port register number |
| ld_data | input | DW | Load-port data |
| pk_addr | input | AW | Peek register number |
| pk_data | output | DW | Peek read data |

## Verification
If the element counter or a latched base were wrong, the very first beat after the start would already carry a wrong `wr_addr`. A corrupted index read would show as wrong `wr_data` in that same beat, or as a trap that comes too early or too late. A fault in the staging buffer or in the commit shows up one cycle after `done`, as peeked register contents that differ from the gathered values. A commit that happens too early shows up as source data that was already overwritten, in the overlapping-area runs. If the sequencer hung or skipped a state, `done` would come at the wrong cycle under steady ready, and this is measured exactly.

// File: rtl/vgather_pkg.sv
package vgather_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_RUN  = 2'd1,
    GS_FIN  = 2'd2
  } gstate_t;
endpackage

// File: rtl/vgather_regfile.sv
// Behavioural register file with a staging buffer.
// During an operation the main array is never written. Accepted beats are
// parked by element number and the whole batch is committed in one edge.
module vgather_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 16,
  parameter int VLMAX = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(VLMAX + 1),
  localparam int EW   = (VLMAX > 1) ? $clog2(VLMAX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] rd_addr0,
  output logic [DW-1:0] rd_data0,
  input  logic [AW-1:0] rd_addr1,
  output logic [DW-1:0] rd_data1,
  input  logic [AW-1:0] rd_addr2,
  output logic [DW-1:0] rd_data2,
  input  logic          st_we,
  input  logic [EW-1:0] st_slot,
  input  logic [DW-1:0] st_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_cnt,
  input  logic [AW-1:0] commit_base
);
  logic [DW-1:0] mem   [NREGS];
  logic [DW-1:0] stage [VLMAX];

  // Staging slots need no reset: only slots written in this operation commit.
  always_ff @(posedge clk) begin
    if (st_we) stage[st_slot] <= st_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREGS; k++) mem[k] <= '0;
    end else begin
      if (ld_we) mem[ld_addr] <= ld_data;
      if (commit) begin
        for (int k = 0; k < VLMAX; k++) begin
          if (CW'(k) < commit_cnt) mem[commit_base + AW'(k)] <= stage[k];
        end
      end
    end
  end

  assign rd_data0 = mem[rd_addr0];
  assign rd_data1 = mem[rd_addr1];
  assign rd_data2 = mem[rd_addr2];
endmodule

// File: rtl/vgather_lane.sv
// Address generation and range check for the current element.
// The index read and the source read chain inside one cycle.
module vgather_lane #(
  parameter int NREGS = 32,
  parameter int DW    = 16,
  parameter int VLMAX = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(VLMAX + 1)
) (
  input  logic [CW-1:0] elem,
  input  logic [CW-1:0] veff,
  input  logic [AW-1:0] ib,
  input  logic [AW-1:0] sb,
  input  logic [AW-1:0] db,
  output logic [AW-1:0] idx_addr,
  input  logic [DW-1:0] idx_val,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          out_of_range
);
  always_comb begin
    idx_addr     = ib + AW'(elem);
    dst_addr     = db + AW'(elem);
    src_addr     = sb + AW'(idx_val);
    out_of_range = (idx_val >= DW'(veff));
  end
endmodule

// File: rtl/vgather_seq.sv
// Operation sequencer: captures operands, steps elements, ends on the
// last accepted beat or on a range fault.
module vgather_seq
  import vgather_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int VLMAX = 8,
  parameter int LENW  = $clog2(VLMAX + 1) + 1,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(VLMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic [AW-1:0]   idx_base,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  input  logic [LENW-1:0] op_len,
  input  logic            out_of_range,
  input  logic            wr_ready,
  output logic            busy,
  output logic            wr_valid,
  output logic            done,
  output logic            trap,
  output logic [CW-1:0]   trap_elem,
  output logic [CW-1:0]   elem,
  output logic [CW-1:0]   veff,
  output logic [CW-1:0]   wcount,
  output logic [AW-1:0]   ib,
  output logic [AW-1:0]   sb,
  output logic [AW-1:0]   db
);
  gstate_t       st;
  logic          trap_q;
  logic [CW-1:0] len_eff;

  always_comb begin
    if (op_len > LENW'(VLMAX)) len_eff = CW'(VLMAX);
    else                       len_eff = op_len[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= GS_IDLE;
      elem      <= '0;
      veff      <= '0;
      wcount    <= '0;
      ib        <= '0;
      sb        <= '0;
      db        <= '0;
      trap_q    <= 1'b0;
      trap_elem <= '0;
    end else begin
      case (st)
        GS_IDLE: begin
          if (op_start) begin
            ib        <= idx_base;
            sb        <= src_base;
            db        <= dst_base;
            veff      <= len_eff;
            elem      <= '0;
            wcount    <= '0;
            trap_q    <= 1'b0;
            trap_elem <= '0;
            st        <= (len_eff == '0) ? GS_FIN : GS_RUN;
          end
        end
        GS_RUN: begin
          if (out_of_range) begin
            trap_q    <= 1'b1;
            trap_elem <= elem;
            st        <= GS_FIN;
          end else if (wr_ready) begin
            wcount <= wcount + CW'(1);
            if (elem == veff - CW'(1)) st <= GS_FIN;
            else                       elem <= elem + CW'(1);
          end
        end
        GS_FIN:  st <= GS_IDLE;
        default: st <= GS_IDLE;
      endcase
    end
  end

  assign busy     = (st != GS_IDLE);
  assign wr_valid = (st == GS_RUN) && !out_of_range;
  assign done     = (st == GS_FIN);
  assign trap     = done && trap_q;
endmodule

// File: rtl/vgather_unit.sv
module vgather_unit #(
  parameter int NREGS = 32,
  parameter int DW    = 16,
  parameter int VLMAX = 8,
  parameter int LENW  = $clog2(VLMAX + 1) + 1,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(VLMAX + 1),
  localparam int EW   = (VLMAX > 1) ? $clog2(VLMAX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic [AW-1:0]   idx_base,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  input  logic [LENW-1:0] op_len,
  output logic            busy,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            done,
  output logic            trap,
  output logic [CW-1:0]   trap_elem,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW-1:0]   ld_data,
  input  logic [AW-1:0]   pk_addr,
  output logic [DW-1:0]   pk_data
);
  logic [CW-1:0] elem, veff, wcount;
  logic [AW-1:0] ib, sb, db;
  logic [AW-1:0] idx_addr, src_addr, dst_addr;
  logic [DW-1:0] idx_val, src_val;
  logic          out_of_range;

  vgather_seq #(.NREGS(NREGS), .VLMAX(VLMAX), .LENW(LENW)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_start(op_start),
    .idx_base(idx_base), .src_base(src_base), .dst_base(dst_base),
    .op_len(op_len), .out_of_range(out_of_range), .wr_ready(wr_ready),
    .busy(busy), .wr_valid(wr_valid), .done(done), .trap(trap),
    .trap_elem(trap_elem), .elem(elem), .veff(veff), .wcount(wcount),
    .ib(ib), .sb(sb), .db(db)
  );

  vgather_lane #(.NREGS(NREGS), .DW(DW), .VLMAX(VLMAX)) u_lane (
    .elem(elem), .veff(veff), .ib(ib), .sb(sb), .db(db),
    .idx_addr(idx_addr), .idx_val(idx_val), .src_addr(src_addr),
    .dst_addr(dst_addr), .out_of_range(out_of_range)
  );

  vgather_regfile #(.NREGS(NREGS), .DW(DW), .VLMAX(VLMAX)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ld_we(ld_we && !busy), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr0(idx_addr), .rd_data0(idx_val),
    .rd_addr1(src_addr), .rd_data1(src_val),
    .rd_addr2(pk_addr),  .rd_data2(pk_data),
    .st_we(wr_valid && wr_ready), .st_slot(elem[EW-1:0]), .st_data(src_val),
    .commit(done), .commit_cnt(wcount), .commit_base(db)
  );

  assign wr_addr = dst_addr;
  assign wr_data = src_val;
endmodule

// File: rtl/vgather_chk.sv
module vgather_chk #(
  parameter int NREGS = 32,
  parameter int DW    = 16,
  parameter int VLMAX = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int CW   = $clog2(VLMAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic          busy,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          done,
  input logic          trap,
  input logic [CW-1:0] trap_elem
);
  logic          seen;
  logic [AW-1:0] last_addr;
  logic [CW:0]   beats;
  logic          hs;

  assign hs = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      last_addr <= '0;
      beats     <= '0;
    end else if (op_start && !busy) begin
      seen  <= 1'b0;
      beats <= '0;
    end else if (hs) begin
      seen      <= 1'b1;
      last_addr <= wr_addr;
      beats     <= beats + 1'b1;
    end
  end

  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hs && seen |-> wr_addr == last_addr + AW'(1)); // R2

  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done && ({1'b0, trap_elem} < (CW+1)'(VLMAX))); // R4

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !wr_valid); // R7

  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> beats < (CW+1)'(VLMAX)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid && !done); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    op_start && !busy |=> busy); // R7
endmodule

bind vgather_unit vgather_chk #(.NREGS(NREGS), .DW(DW), .VLMAX(VLMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .busy(busy),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .done(done), .trap(trap), .trap_elem(trap_elem)
);

// File: tb/vgather_unit_tb.sv
`timescale 1ns/1ps
module vgather_unit_tb;
  localparam int NREGS = 32;
  localparam int DW    = 16;
  localparam int VLMAX = 8;
  localparam int LENW  = 5;
  localparam int AW    = 5;
  localparam int CW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, op_start, wr_ready, ld_we;
  logic [AW-1:0]   idx_base, src_base, dst_base, ld_addr, pk_addr;
  logic [LENW-1:0] op_len;
  logic            busy, wr_valid, done, trap;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data, ld_data, pk_data;
  logic [CW-1:0]   trap_elem;

  vgather_unit #(.NREGS(NREGS), .DW(DW), .VLMAX(VLMAX), .LENW(LENW)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .idx_base(idx_base),
    .src_base(src_base), .dst_base(dst_base), .op_len(op_len), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .trap(trap), .trap_elem(trap_elem),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pk_addr(pk_addr), .pk_data(pk_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] model [NREGS];
  logic [15:0]   lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic load(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    model[a] = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic peek_all(input string req);
    for (int a = 0; a < NREGS; a++) begin
      pk_addr = AW'(a);
      #0.05;
      chk(pk_data == model[a], req, $sformatf("reg %0d", a), pk_data, model[a]);
    end
  endtask

  // rmode 0: ready always high; 1: pseudo-random ready. inject: start/load while busy.
  task automatic run_op(input int ra, input int rb, input int rd, input int len,
                        input int rmode, input bit inject);
    int veff, nexp, te, n, hold_a, hold_d;
    bit etrap, holding;
    logic [DW-1:0] idx;
    logic [DW-1:0] ed [VLMAX];
    int ea [VLMAX];
    veff = (len > VLMAX) ? VLMAX : len;
    etrap = 1'b0; te = 0; nexp = 0;
    for (int i = 0; i < veff; i++) begin
      idx = model[(ra + i) % NREGS];
      if (idx >= DW'(veff)) begin etrap = 1'b1; te = i; break; end
      ea[i] = (rd + i) % NREGS;
      ed[i] = model[(rb + int'(idx)) % NREGS];
      nexp++;
    end
    @(negedge clk);
    op_start = 1'b1; idx_base = AW'(ra); src_base = AW'(rb);
    dst_base = AW'(rd); op_len = LENW'(len);
    n = 0; holding = 1'b0; hold_a = 0; hold_d = 0;
    for (int it = 0; ; it++) begin
      @(negedge clk);
      op_start = 1'b0; ld_we = 1'b0;
      if (inject && it == 1) begin
        op_start = 1'b1; idx_base = 5'd9; src_base = 5'd3; dst_base = 5'd2; op_len = 5'd3;
        ld_we = 1'b1; ld_addr = 5'd31; ld_data = 16'h5A5A;
      end
      if (rmode == 0) wr_ready = 1'b1;
      else begin
        wr_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      #1;
      if (holding)
        chk(wr_valid && wr_addr == AW'(hold_a) && wr_data == DW'(hold_d), "R6",
            "stalled beat changed", {wr_valid, wr_addr, wr_data}, {1'b1, AW'(hold_a), DW'(hold_d)});
      holding = wr_valid && !wr_ready;
      hold_a = wr_addr; hold_d = wr_data;
      if (wr_valid && wr_ready) begin
        chk(n < nexp, "R4", "beat count", n, nexp);
        if (n < nexp) begin
          chk(wr_addr == AW'(ea[n]), "R2", $sformatf("addr elem %0d", n), wr_addr, ea[n]);
          chk(wr_data == ed[n], "R3", $sformatf("data elem %0d", n), wr_data, ed[n]);
        end
        n++;
      end
      if (done) begin
        chk(trap == etrap, "R4", "trap flag", trap, etrap);
        if (etrap) chk(trap_elem == CW'(te), "R4", "trap element", trap_elem, te);
        chk(n == nexp, "R7", "beats before done", n, nexp);
        if (rmode == 0) chk(it == (etrap ? te + 1 : veff), "R7", "done cycle", it, etrap ? te + 1 : veff);
        break;
      end
      if (it > 300) begin
        chk(1'b0, "R7", "done never seen", it, 0);
        break;
      end
    end
    wr_ready = 1'b0; ld_we = 1'b0;
    // The bench model commits only after done, mirroring the register view from the cycle after done.
    for (int i = 0; i < nexp; i++) model[ea[i]] = ed[i];
    @(negedge clk);
    chk(!busy && !done, "R7", "idle after done", {busy, done}, 0);
    peek_all("R5");
  endtask

  initial begin
    rst_n = 1'b0; op_start = 1'b0; wr_ready = 1'b0; ld_we = 1'b0;
    idx_base = '0; src_base = '0; dst_base = '0; op_len = '0;
    ld_addr = '0; ld_data = '0; pk_addr = '0;
    for (int a = 0; a < NREGS; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !done && !trap, "R1", "reset outputs",
        {busy, wr_valid, done, trap}, 0);
    peek_all("R1");
    rst_n = 1'b1;

    for (int a = 0; a < NREGS; a++) load(a, DW'(a * 37 + 100));
    peek_all("R10");

    // Full permutation.
    begin
      int p [8] = '{3, 7, 2, 5, 1, 0, 4, 6};
      for (int i = 0; i < 8; i++) load(i, DW'(p[i]));
    end
    run_op(0, 8, 16, 8, 0, 1'b0);

    // Duplicated indices, under back-pressure.
    begin
      int p [7] = '{5, 5, 3, 3, 4, 4, 4};
      for (int i = 0; i < 7; i++) load(i, DW'(p[i]));
    end
    run_op(0, 8, 16, 7, 1, 1'b0);

    // Trap at element 3 (index equals length).
    load(0, 1); load(1, 2); load(2, 0); load(3, 4);
    run_op(0, 8, 20, 4, 0, 1'b0);

    // In-place reverse: destination equals source area.
    for (int i = 0; i < 8; i++) load(24 + i, DW'(7 - i));
    run_op(24, 8, 8, 8, 0, 1'b0);

    // Zero length.
    run_op(0, 8, 16, 0, 0, 1'b0);

    // Length clamp R8: 20 behaves as 8, index 8 at element 7 traps.
    for (int i = 0; i < 8; i++) load(i, DW'(i));
    run_op(0, 8, 16, 20, 0, 1'b0);
    load(7, 8);
    run_op(0, 8, 16, 20, 0, 1'b0);

    // Start and load while busy are ignored (R9).
    for (int i = 0; i < 8; i++) load(i, DW'((i * 3) % 8));
    run_op(0, 12, 18, 8, 1, 1'b1);

    // Sweep of lengths and index patterns, with overlapping areas.
    for (int len = 1; len <= VLMAX; len++)
      for (int a = 1; a <= 7; a += 2)
        for (int b = 0; b < 3; b++) begin
          for (int i = 0; i < len; i++) load(i, DW'((a * i + b) % (len + 1)));
          run_op(0, (a * 4 + b) % NREGS, (b == 2) ? 0 : 16 + a, len, b % 2, 1'b0);
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule